// File: doc/BRIEF.md
# Two-Wire Slave Protocol Engine

This block is the bus-facing front end of a two-wire serial slave that serves two internal address spaces: a main memory array and a clock/control register space. It receives oversampled clock and data lines, finds start and stop conditions, and checks the 7-bit identity in the first byte of a transfer. It pulls the data line low for acknowledge bits and for zero data bits. It collects a 16-bit word address and keeps a current-address counter that both reads and writes advance.

Received data bytes go to a downstream write sequencer as one-cycle strobes that carry the target, the address and the byte. Read data comes back from storage combinationally for the address and target the engine presents. While the downstream write cycle runs, the sequencer holds `busy_i`, and the engine gives no response of any kind. The open-drain pad, the storage and the write-cycle timing are outside this block.

Top module: `twi_slave_engine`

## Requirements
- R1: The first byte after a start is accepted only when its bits [7:1] equal 1010111 or 1101111. On acceptance, `sda_drive_low_o` is 1 during the ninth clock of that byte. On any other value the line stays released and the byte is not acknowledged.
- R2: Bits [7:4] of the accepted first byte pick the target: 1010 gives target 0 (memory array) and 1101 gives target 1 (control registers). The target appears on `wr_tgt_o` and `rd_tgt_o`.
- R3: Bit 0 of the first byte is the direction (1 read, 0 write). A write is followed by two address bytes, high byte first, and each is acknowledged. After the second byte the address counter holds the 16-bit value.
- R4: Every data byte of a write after the address bytes is acknowledged and produces a one-cycle `wr_stb_o` carrying the counter value, the byte and the target. The counter then advances by one.
- R5: The address counter is 0 after reset, so a read with no address phase returns the data at address 0.
- R6: Read bytes are sent MSB first, taken from `rd_data_i` at the counter value. The counter advances by one after each byte sent. While the master acknowledges, the next byte follows from the new address.
- R7: After a write has set the address, a read first byte must name the same target (same bits [7:4]) as the write before it, or it is not acknowledged. A stop clears this constraint.
- R8: When the master does not acknowledge a read byte, the engine releases the line and ignores everything, repeated starts included, until a stop.
- R9: While `busy_i` is 1 the engine acknowledges nothing, raises no strobe, and releases the line by the next cycle. This holds even when busy rises in the cycle a byte completes.
- R10: A start or a stop in the middle of a byte aborts the transfer without a strobe. A start makes the engine wait for a new first byte, and the address counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| busy_i | input | 1 | Downstream write cycle in progress |
| sda_drive_low_o | output | 1 | 1 pulls the data line low |
| rd_addr_o | output | AW | Current address counter |
| rd_tgt_o | output | 1 | Target for the read data lookup |
| rd_data_i | input | 8 | Storage byte at rd_addr_o / rd_tgt_o |
| wr_stb_o | output | 1 | One-cycle strobe for a received data byte |
| wr_tgt_o | output | 1 | Target of the strobed byte |
| wr_addr_o | output | AW | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |

## Verification
The completion of a received data byte and a rising `busy_i` can land in the same clock cycle, and busy must win: no strobe appears, no acknowledge is driven, and the counter does not advance. The bench provokes this by raising busy at the moment the master lifts the clock for the eighth data bit. That edge reaches the engine through the synchroniser a few cycles later, while busy is already high. It then judges the outcome at the ports: the strobe count stays the same, the ninth bit reads as a not-acknowledge, and the drive output is low.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXD, S_ACK, S_TX, S_MACK, S_WSTOP
  } twi_state_t;

  typedef enum logic [1:0] {
    P_DEV, P_AHI, P_ALO, P_WDAT
  } twi_phase_t;

  localparam logic [3:0] ID_ARRAY = 4'b1010;
  localparam logic [3:0] ID_CTRL  = 4'b1101;
  localparam logic [2:0] DEV_SEL  = 3'b111;

  // identity compare on bits [7:1]
  function automatic logic twi_id_hit(input logic [7:0] b);
    return ((b[7:4] == ID_ARRAY) || (b[7:4] == ID_CTRL)) && (b[3:1] == DEV_SEL);
  endfunction

  // 1 selects the control/clock space
  function automatic logic twi_id_tgt(input logic [7:0] b);
    return b[7:4] == ID_CTRL;
  endfunction

  // reads after an address phase must keep the same target
  function automatic logic twi_dev_accept(input logic [7:0] b, input logic pend_v,
                                          input logic pend_tgt);
    return twi_id_hit(b) && !(b[0] && pend_v && (twi_id_tgt(b) != pend_tgt));
  endfunction

  function automatic twi_phase_t twi_next_phase(input twi_phase_t p);
    case (p)
      P_DEV:   return P_AHI;
      P_AHI:   return P_ALO;
      default: return P_WDAT;
    endcase
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_s, scl_q, sda_q;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + AW'(1);
  end
endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic       din,
  output logic [7:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[6:0], din};
  end
endmodule

// File: rtl/twi_slave_engine.sv
module twi_slave_engine
  import twi_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          busy_i,
  output logic          sda_drive_low_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_tgt_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_stb_o,
  output logic          wr_tgt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  localparam logic [3:0] LAST_RX = 4'd7;
  localparam logic [3:0] LAST_TX = 4'd8;

  // internal events, named for the checker
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_done, tx_done, tx_begin;
  logic ctr_load, ctr_inc;
  logic sh_load, sh_shift, sh_din;
  logic [7:0] sh_q, rx_byte;
  logic [AW-1:0] ctr_q;

  twi_state_t st;
  twi_phase_t phase;
  logic [3:0] bitcnt;
  logic       rw_q, tgt_q, mack_q, pend_v, pend_tgt;
  logic [7:0] ahi_q;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val(AW'({ahi_q, rx_byte})), .inc(ctr_inc), .q(ctr_q)
  );

  twi_byte_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(rd_data_i),
    .shift(sh_shift), .din(sh_din), .q(sh_q)
  );

  always_comb begin
    rx_byte   = {sh_q[6:0], sda_s};
    byte_done = !busy_i && (st == S_RX) && scl_rise && (bitcnt == LAST_RX);
    tx_done   = !busy_i && (st == S_TX) && scl_fall && (bitcnt == LAST_TX);
    tx_begin  = !busy_i && scl_fall &&
                (((st == S_ACK) && (phase == P_DEV) && rw_q) ||
                 ((st == S_MACK) && mack_q));
    ctr_load  = byte_done && (phase == P_ALO);
    ctr_inc   = (byte_done && (phase == P_WDAT)) || tx_done;
    sh_load   = tx_begin;
    sh_shift  = !busy_i && (((st == S_RX) && scl_rise) ||
                            ((st == S_TX) && scl_fall && (bitcnt != LAST_TX)));
    sh_din    = (st == S_RX) ? sda_s : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      phase           <= P_DEV;
      bitcnt          <= '0;
      rw_q            <= 1'b0;
      tgt_q           <= 1'b0;
      mack_q          <= 1'b0;
      pend_v          <= 1'b0;
      pend_tgt        <= 1'b0;
      ahi_q           <= '0;
      sda_drive_low_o <= 1'b0;
      wr_stb_o        <= 1'b0;
      wr_addr_o       <= '0;
      wr_data_o       <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (busy_i) begin
        st              <= S_IDLE;
        sda_drive_low_o <= 1'b0;
        pend_v          <= 1'b0;
      end else if (stop_evt) begin
        st              <= S_IDLE;
        sda_drive_low_o <= 1'b0;
        pend_v          <= 1'b0;
      end else if (start_evt && (st != S_WSTOP)) begin
        st              <= S_RX;
        phase           <= P_DEV;
        bitcnt          <= '0;
        sda_drive_low_o <= 1'b0;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            if (bitcnt == LAST_RX) begin
              bitcnt <= '0;
              st     <= S_RXD;
              case (phase)
                P_DEV: begin
                  if (twi_dev_accept(rx_byte, pend_v, pend_tgt)) begin
                    rw_q  <= rx_byte[0];
                    tgt_q <= twi_id_tgt(rx_byte);
                  end else begin
                    st <= S_IDLE;
                  end
                end
                P_AHI: ahi_q <= rx_byte;
                P_ALO: begin
                  pend_v   <= 1'b1;
                  pend_tgt <= tgt_q;
                end
                default: begin
                  wr_stb_o  <= 1'b1;
                  wr_addr_o <= ctr_q;
                  wr_data_o <= rx_byte;
                end
              endcase
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          S_RXD: if (scl_fall) begin
            sda_drive_low_o <= 1'b1;
            st              <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if ((phase == P_DEV) && rw_q) begin
              sda_drive_low_o <= ~rd_data_i[7];
              st              <= S_TX;
            end else begin
              sda_drive_low_o <= 1'b0;
              phase           <= twi_next_phase(phase);
              st              <= S_RX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_TX) begin
                sda_drive_low_o <= 1'b0;
                st              <= S_MACK;
              end else begin
                sda_drive_low_o <= ~sh_q[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                sda_drive_low_o <= ~rd_data_i[7];
                bitcnt          <= '0;
                st              <= S_TX;
              end else begin
                st <= S_WSTOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ctr_q;
  assign rd_tgt_o  = tgt_q;
  assign wr_tgt_o  = tgt_q;
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          sda_low,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          scl_fall_evt,
  input logic          start_evt,
  input logic          stop_evt
);
  // R9: busy frees the line by the next cycle
  a_r9_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_low);

  // R9: no strobe right after a busy cycle
  a_r9_busy_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(busy_i));

  // R4: strobe lasts one cycle
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R4: counter is one past the strobed address
  a_r4_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (rd_addr == AW'(wr_addr + AW'(1))));

  // R10: start releases the line
  a_r10_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_low);

  // R10: stop releases the line
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_low);

  // R1: the line is only pulled low after a clock fall
  a_r1_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(scl_fall_evt));
endmodule

bind twi_slave_engine twi_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_low(sda_drive_low_o),
  .wr_stb(wr_stb_o), .wr_addr(wr_addr_o), .rd_addr(rd_addr_o),
  .scl_fall_evt(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/sim_twi_slave_engine.sv
module sim_twi_slave_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_low, rd_tgt, wr_stb, wr_tgt;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic sda_line;

  int checks = 0, fails = 0, n_stb = 0;
  logic [15:0] s_addr[64];
  logic [7:0]  s_data[64];
  logic        s_tgt[64];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  function automatic logic [7:0] mdata(input logic t, input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ (t ? 8'hC3 : 8'h5A);
  endfunction
  function automatic logic [7:0] dev_byte(input logic t, input logic rd);
    return {(t ? 4'b1101 : 4'b1010), 3'b111, rd};
  endfunction
  assign rd_data = mdata(rd_tgt, rd_addr);

  twi_slave_engine u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .busy_i(busy),
    .sda_drive_low_o(sda_low), .rd_addr_o(rd_addr), .rd_tgt_o(rd_tgt),
    .rd_data_i(rd_data), .wr_stb_o(wr_stb), .wr_tgt_o(wr_tgt),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_stb) begin
    if (n_stb < 64) begin
      s_addr[n_stb] = wr_addr; s_data[n_stb] = wr_data; s_tgt[n_stb] = wr_tgt;
    end
    n_stb++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(); repeat (HALF) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; hw(); scl_m = 1; hw(); sda_m = 0; hw(); scl_m = 0; hw(); endtask
  task automatic bus_stop();  sda_m = 0; hw(); scl_m = 1; hw(); sda_m = 1; hw(); endtask
  task automatic put_bit(input logic b); sda_m = b; hw(); scl_m = 1; hw(); scl_m = 0; hw(); endtask
  task automatic get_bit(output logic b);
    sda_m = 1; hw(); scl_m = 1;
    repeat (HALF/2) @(negedge clk); b = sda_line;
    repeat (HALF/2) @(negedge clk); scl_m = 0; hw();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x); ack = ~x;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~mack);
  endtask

  task automatic addr_phase(input logic t, input logic [15:0] a);
    logic ack;
    bus_start();
    send_byte(dev_byte(t, 1'b0), ack); chk(ack, "R1", "write identity ack", ack, 1);
    send_byte(a[15:8], ack);            chk(ack, "R3", "high address ack", ack, 1);
    send_byte(a[7:0], ack);             chk(ack, "R3", "low address ack", ack, 1);
  endtask

  task automatic do_write(input logic t, input logic [15:0] a, input int n);
    logic ack; logic [7:0] d[8]; int n0;
    n0 = n_stb;
    addr_phase(t, a);
    for (int i = 0; i < n; i++) begin
      d[i] = 8'($urandom);
      send_byte(d[i], ack); chk(ack, "R4", "data ack", ack, 1);
    end
    bus_stop(); hw();
    chk(n_stb == n0 + n, "R4", "strobe count", n_stb, n0 + n);
    for (int i = 0; i < n; i++) if (n0 + i < 64) begin
      chk(s_addr[n0+i] == 16'(a + i), "R4", "strobe address", s_addr[n0+i], 16'(a + i));
      chk(s_data[n0+i] == d[i], "R4", "strobe data", s_data[n0+i], d[i]);
      chk(s_tgt[n0+i] == t, "R2", "strobe target", s_tgt[n0+i], t);
    end
  endtask

  task automatic do_read(input logic t, input logic [15:0] a, input int n);
    logic ack; logic [7:0] b;
    addr_phase(t, a);
    bus_start();
    send_byte(dev_byte(t, 1'b1), ack); chk(ack, "R7", "matching read identity ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == mdata(t, 16'(a + i)), "R6", "read byte", b, mdata(t, 16'(a + i)));
    end
    bus_stop();
    chk(rd_addr == 16'(a + n), "R6", "counter after read", rd_addr, 16'(a + n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack, t; logic [7:0] b; logic [15:0] a; int n0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(sda_low == 0, "R9", "reset drive", sda_low, 0);
    chk(wr_stb == 0, "R4", "reset strobe", wr_stb, 0);
    chk(rd_addr == 0, "R5", "reset counter", rd_addr, 0);
    rst_n = 1; hw();

    // R5: current-address read from reset
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), ack); chk(ack, "R1", "read identity ack", ack, 1);
    recv_byte(1'b0, b); chk(b == mdata(0, 0), "R5", "first read at 0", b, mdata(0, 0));
    bus_stop();

    // random writes and reads
    for (int k = 0; k < 6; k++) begin
      t = 1'($urandom); a = 16'($urandom);
      do_write(t, a, 1 + int'($urandom % 5));
      t = 1'($urandom); a = 16'($urandom);
      do_read(t, a, 1 + int'($urandom % 4));
    end
    do_write(1'b1, 16'hFFFF, 2);
    do_read(1'b0, 16'hFFFE, 3);

    // R1: identities that do not match
    for (int k = 0; k < 4; k++) begin
      do b = 8'($urandom); while (b[7:1] == 7'b1010111 || b[7:1] == 7'b1101111);
      bus_start(); send_byte(b, ack);
      chk(!ack, "R1", "foreign identity nack", ack, 0); bus_stop();
    end
    bus_start(); send_byte(8'b1010_1100, ack);
    chk(!ack, "R1", "wrong select bits nack", ack, 0); bus_stop();

    // R7: read identity differs from the dummy write
    addr_phase(1'b0, 16'h1234); bus_start();
    send_byte(dev_byte(1'b1, 1'b1), ack);
    chk(!ack, "R7", "target mismatch nack", ack, 0); bus_stop();

    // R8: after master nack, repeated start is ignored until stop
    addr_phase(1'b1, 16'h0420); bus_start();
    send_byte(dev_byte(1'b1, 1'b1), ack); recv_byte(1'b0, b);
    bus_start(); send_byte(dev_byte(1'b1, 1'b1), ack);
    chk(!ack, "R8", "ignored until stop", ack, 0);
    bus_stop(); bus_start(); send_byte(dev_byte(1'b1, 1'b1), ack);
    chk(ack, "R8", "ack after stop", ack, 1);
    recv_byte(1'b0, b);
    chk(b == mdata(1, 16'h0421), "R8", "resume at next address", b, mdata(1, 16'h0421));
    bus_stop();

    // R9: busy during a whole transfer
    n0 = n_stb; busy = 1;
    bus_start(); send_byte(dev_byte(1'b0, 1'b0), ack);
    chk(!ack, "R9", "busy nack", ack, 0); bus_stop();
    chk(sda_low == 0, "R9", "busy line released", sda_low, 0);
    busy = 0; hw();
    chk(n_stb == n0, "R9", "busy no strobe", n_stb, n0);

    // R9: busy rises as a data byte completes
    n0 = n_stb; b = 8'($urandom);
    addr_phase(1'b0, 16'h0777);
    for (int i = 7; i >= 1; i--) put_bit(b[i]);
    sda_m = b[0]; hw(); scl_m = 1; busy = 1; hw(); scl_m = 0; hw();
    get_bit(ack);
    chk(ack == 1, "R9", "no ack when busy wins", ~ack, 0);
    chk(sda_low == 0, "R9", "line released", sda_low, 0);
    bus_stop(); busy = 0; hw();
    chk(n_stb == n0, "R9", "no strobe when busy wins", n_stb, n0);
    chk(rd_addr == 16'h0777, "R9", "counter held", rd_addr, 16'h0777);

    // R10: start in mid-byte
    n0 = n_stb;
    addr_phase(1'b1, 16'h5A00);
    put_bit(1); put_bit(0); put_bit(1);
    bus_start(); send_byte(dev_byte(1'b1, 1'b1), ack);
    chk(ack, "R10", "identity after abort", ack, 1);
    recv_byte(1'b0, b);
    chk(b == mdata(1, 16'h5A00), "R10", "counter kept", b, mdata(1, 16'h5A00));
    bus_stop(); hw();
    chk(n_stb == n0, "R10", "no strobe on start abort", n_stb, n0);

    // R10: stop in mid-byte
    addr_phase(1'b0, 16'h0100);
    for (int i = 0; i < 5; i++) put_bit(1'($urandom));
    bus_stop(); hw();
    chk(n_stb == n0, "R10", "no strobe on stop abort", n_stb, n0);
    chk(rd_addr == 16'h0100, "R10", "counter after stop abort", rd_addr, 16'h0100);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule